// File: doc/BRIEF.md
# Edge-Timestamp Bounded-Always Monitor

This block decides, for a single boolean signal, where the bounded "always over [a, b]" operator holds. It does not buffer samples. It takes one event at a time. Each event is a timestamp plus a polarity bit that says whether the signal rose or fell. The two interval bounds are held on inputs. When a high pulse of the watched signal closes, the block derives the matching high pulse of the operator's result. It then issues that pulse as two timestamped events, the rise first and the fall second.

Each pulse costs two subtractions: the lower bound is taken from the pulse's start and the upper bound from its end. Storage does not grow with the interval width or with the sample rate. The block keeps the pending rise time and one held result timestamp. The output register holds the other result timestamp. Control is a four-state machine encoded in two bits.

Out-of-order protocol events are dropped and raise a sticky error flag. A synchronous reset clears the flag. At reset an initial-level input says whether the watched signal starts high.

Top module: `gmon_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` and `proto_err` are 0, and `in_ready` is 1 unless a result is pending.
- R2: For a closed input pulse with rise time tr and fall time tf, two output events are issued in order. The first has `out_rise`=1 and `out_ts`=tr-lo. The second has `out_rise`=0 and `out_ts`=tf-hi. A rising event is encoded as `in_rise`/`out_rise`=1 and a falling event as 0.
- R3: When tr-lo is below zero, the rise timestamp issued is 0.
- R4: The pair is issued only when the (clamped) rise timestamp is strictly smaller than tf-hi. Otherwise nothing is issued and the block goes back to waiting for a rise. This covers the equal case and the case where tf-hi is negative.
- R5: When `init_level` is 1 during reset, the block starts as if a rise had been seen at time 0. The first event it accepts may then be a fall.
- R6: A falling event that arrives while the block is waiting for a rise is dropped and sets `proto_err`. The flag stays set until reset.
- R7: A rising event that arrives while a rise is already pending is dropped and sets `proto_err`. The earlier rise time is kept.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_ts` and `out_rise` hold their values. While a result is pending, `in_ready` is 0.
- R9: The rising result event shows up on `out_valid` on the cycle right after the clock edge that accepted the closing fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_level | input | 1 | Starting level of the watched signal, sampled while in reset |
| lo_bound | input | TS_W | Lower interval bound a |
| hi_bound | input | TS_W | Upper interval bound b |
| in_valid | input | 1 | Input event present |
| in_ready | output | 1 | Block can take an input event |
| in_rise | input | 1 | Input event polarity, 1 = rising, 0 = falling |
| in_ts | input | TS_W | Input event timestamp |
| out_valid | output | 1 | Result event present |
| out_ready | input | 1 | Consumer takes the result event |
| out_rise | output | 1 | Result event polarity, 1 = rising, 0 = falling |
| out_ts | output | TS_W | Result event timestamp |
| proto_err | output | 1 | Sticky flag for a dropped out-of-order event |

## Verification
Two kinds of internal corruption reach the ports quickly. A wrong stored rise time shows up in `out_ts` on the rise beat issued right after the next closing fall. A wrong control state shows up at once as a mismatch between `in_ready` and `out_valid`, or as a dropped event that should have raised `proto_err`. The reference model therefore compares `in_ready`, `out_valid`, `proto_err` and every result beat on every cycle. A divergence is reported within one clock of its first visible effect. The stimulus covers a clamped rise, an exactly equal rise/fall pair and a negative fall. It also covers a start at high level, both kinds of out-of-order event, and a stalling consumer.

// File: rtl/gmon_pkg.sv
package gmon_pkg;

  typedef enum logic [1:0] {
    ST_LOW    = 2'd0,
    ST_HIGH   = 2'd1,
    ST_EMIT_R = 2'd2,
    ST_EMIT_F = 2'd3
  } gmon_state_e;

endpackage

// File: rtl/gmon_calc.sv
module gmon_calc #(
  parameter int TS_W = 32
) (
  input  logic [TS_W-1:0] rise_ts,
  input  logic [TS_W-1:0] fall_ts,
  input  logic [TS_W-1:0] lo_bound,
  input  logic [TS_W-1:0] hi_bound,
  output logic [TS_W-1:0] res_rise_ts,
  output logic [TS_W-1:0] res_fall_ts,
  output logic            keep
);

  localparam int EW = TS_W + 1;

  logic signed [EW-1:0] rise_diff;
  logic signed [EW-1:0] rise_clamped;
  logic signed [EW-1:0] fall_diff;

  always_comb begin
    rise_diff    = $signed({1'b0, rise_ts}) - $signed({1'b0, lo_bound});
    fall_diff    = $signed({1'b0, fall_ts}) - $signed({1'b0, hi_bound});
    rise_clamped = rise_diff[EW-1] ? '0 : rise_diff;
    keep         = rise_clamped < fall_diff;
    res_rise_ts  = rise_clamped[TS_W-1:0];
    res_fall_ts  = fall_diff[TS_W-1:0];
  end

endmodule

// File: rtl/gmon_ctrl.sv
module gmon_ctrl
  import gmon_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            init_level,
  input  logic            in_valid,
  input  logic            in_rise,
  input  logic [TS_W-1:0] in_ts,
  input  logic            keep,
  input  logic            out_fire,
  output logic            in_ready,
  output logic            load_result,
  output logic [TS_W-1:0] rise_hold,
  output logic            err
);

  gmon_state_e     state_q;
  logic [TS_W-1:0] rise_q;
  logic            err_q;
  logic            accept;

  assign in_ready    = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign accept      = in_valid && in_ready;
  assign load_result = accept && (state_q == ST_HIGH) && !in_rise && keep;
  assign rise_hold   = rise_q;
  assign err         = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= init_level ? ST_HIGH : ST_LOW;
      rise_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_LOW: begin
          if (accept) begin
            if (in_rise) begin
              rise_q  <= in_ts;
              state_q <= ST_HIGH;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_HIGH: begin
          if (accept) begin
            if (in_rise) begin
              err_q <= 1'b1;
            end else begin
              state_q <= keep ? ST_EMIT_R : ST_LOW;
            end
          end
        end
        ST_EMIT_R: begin
          if (out_fire) state_q <= ST_EMIT_F;
        end
        ST_EMIT_F: begin
          if (out_fire) state_q <= ST_LOW;
        end
        default: state_q <= ST_LOW;
      endcase
    end
  end

endmodule

// File: rtl/gmon_out_stage.sv
module gmon_out_stage #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [TS_W-1:0] load_rise_ts,
  input  logic [TS_W-1:0] load_fall_ts,
  input  logic            out_ready,
  output logic            out_valid,
  output logic            out_rise,
  output logic [TS_W-1:0] out_ts
);

  logic [TS_W-1:0] fall_hold_q;
  logic            fire;

  assign fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_rise    <= 1'b0;
      out_ts      <= '0;
      fall_hold_q <= '0;
    end else if (load) begin
      out_valid   <= 1'b1;
      out_rise    <= 1'b1;
      out_ts      <= load_rise_ts;
      fall_hold_q <= load_fall_ts;
    end else if (fire) begin
      if (out_rise) begin
        out_rise <= 1'b0;
        out_ts   <= fall_hold_q;
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/gmon_top.sv
module gmon_top #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            init_level,
  input  logic [TS_W-1:0] lo_bound,
  input  logic [TS_W-1:0] hi_bound,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_rise,
  input  logic [TS_W-1:0] in_ts,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_rise,
  output logic [TS_W-1:0] out_ts,
  output logic            proto_err
);

  logic [TS_W-1:0] rise_hold;
  logic [TS_W-1:0] res_rise_ts;
  logic [TS_W-1:0] res_fall_ts;
  logic            keep;
  logic            load_result;
  logic            out_fire;

  assign out_fire = out_valid && out_ready;

  gmon_calc #(.TS_W(TS_W)) u_calc (
    .rise_ts     (rise_hold),
    .fall_ts     (in_ts),
    .lo_bound    (lo_bound),
    .hi_bound    (hi_bound),
    .res_rise_ts (res_rise_ts),
    .res_fall_ts (res_fall_ts),
    .keep        (keep)
  );

  gmon_ctrl #(.TS_W(TS_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .init_level  (init_level),
    .in_valid    (in_valid),
    .in_rise     (in_rise),
    .in_ts       (in_ts),
    .keep        (keep),
    .out_fire    (out_fire),
    .in_ready    (in_ready),
    .load_result (load_result),
    .rise_hold   (rise_hold),
    .err         (proto_err)
  );

  gmon_out_stage #(.TS_W(TS_W)) u_out (
    .clk          (clk),
    .rst          (rst),
    .load         (load_result),
    .load_rise_ts (res_rise_ts),
    .load_fall_ts (res_fall_ts),
    .out_ready    (out_ready),
    .out_valid    (out_valid),
    .out_rise     (out_rise),
    .out_ts       (out_ts)
  );

endmodule

// File: rtl/gmon_checks.sv
module gmon_checks #(
  parameter int TS_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_rise,
  input logic [TS_W-1:0] out_ts,
  input logic            proto_err
);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_ts) && $stable(out_rise));

  p_block_input_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  p_rise_leads_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_rise);

  p_fall_follows_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_rise |=> out_valid && !out_rise);

  p_pair_ends_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !out_rise |=> !out_valid);

  p_order_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_rise |=> out_ts > $past(out_ts));

endmodule

bind gmon_top gmon_checks #(.TS_W(TS_W)) u_gmon_checks (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_rise  (out_rise),
  .out_ts    (out_ts),
  .proto_err (proto_err)
);

// File: tb/gmon_top_bench.sv
`timescale 1ns/1ps
module gmon_top_bench;
  localparam int TS_W = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            init_level = 1'b0;
  logic [TS_W-1:0] lo_bound = '0;
  logic [TS_W-1:0] hi_bound = '0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic            in_rise = 1'b0;
  logic [TS_W-1:0] in_ts = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic            out_rise;
  logic [TS_W-1:0] out_ts;
  logic            proto_err;

  always #2.5 clk = ~clk;

  gmon_top #(.TS_W(TS_W)) u_gmon_top (
    .clk(clk), .rst(rst), .init_level(init_level), .lo_bound(lo_bound),
    .hi_bound(hi_bound), .in_valid(in_valid), .in_ready(in_ready),
    .in_rise(in_rise), .in_ts(in_ts), .out_valid(out_valid),
    .out_ready(out_ready), .out_rise(out_rise), .out_ts(out_ts),
    .proto_err(proto_err)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    bp_on = 1'b0;
  int    rdy_cnt = 0;

  // behavioural reference state
  bit     m_high;
  longint m_tr;
  bit     m_err;
  bit     q_pol[$];
  longint q_ts[$];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_accept(bit pol, longint ts);
    longint r;
    longint f;
    if (!m_high) begin
      if (pol) begin m_high = 1'b1; m_tr = ts; end
      else m_err = 1'b1;
    end else if (pol) begin
      m_err = 1'b1;
    end else begin
      m_high = 1'b0;
      r = m_tr - longint'(lo_bound);
      if (r < 0) r = 0;
      f = ts - longint'(hi_bound);
      if (r < f) begin
        q_pol.push_back(1'b1); q_ts.push_back(r);
        q_pol.push_back(1'b0); q_ts.push_back(f);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      m_high = init_level; m_tr = 0; m_err = 1'b0;
      q_pol.delete(); q_ts.delete();
    end else begin
      check(out_valid == (q_pol.size() > 0), cur_req, "out_valid", longint'(out_valid), longint'(q_pol.size() > 0));
      check(in_ready == (q_pol.size() == 0), cur_req, "in_ready", longint'(in_ready), longint'(q_pol.size() == 0));
      check(proto_err == m_err, cur_req, "proto_err", longint'(proto_err), longint'(m_err));
      if (out_valid && q_pol.size() > 0) begin
        check(out_rise == q_pol[0], cur_req, "out_rise", longint'(out_rise), longint'(q_pol[0]));
        check(longint'(out_ts) == q_ts[0], cur_req, "out_ts", longint'(out_ts), q_ts[0]);
      end
      if (out_valid && out_ready && q_pol.size() > 0) begin
        void'(q_pol.pop_front()); void'(q_ts.pop_front());
      end
      if (in_valid && in_ready) model_accept(in_rise, longint'(in_ts));
    end
  end

  always @(posedge clk) begin
    #1;
    rdy_cnt++;
    out_ready = bp_on ? ((rdy_cnt % 3) == 2) : 1'b1;
  end

  task automatic do_reset(bit init, logic [TS_W-1:0] a, logic [TS_W-1:0] b);
    @(posedge clk); #1;
    rst = 1'b1; init_level = init; lo_bound = a; hi_bound = b; in_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic send(bit pol, logic [TS_W-1:0] ts);
    @(posedge clk); #1;
    in_valid = 1'b1; in_rise = pol; in_ts = ts;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!out_valid && in_ready) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    longint t;
    cur_req = "R1";
    do_reset(1'b0, 32'd5, 32'd3);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
    check(proto_err == 1'b0, "R1", "proto_err after reset", longint'(proto_err), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", longint'(in_ready), 1);

    cur_req = "R2";
    send(1'b1, 32'd100); send(1'b0, 32'd200); drain();
    cur_req = "R9";
    send(1'b1, 32'd300); send(1'b0, 32'd340); drain();

    cur_req = "R3";
    do_reset(1'b0, 32'd50, 32'd3);
    send(1'b1, 32'd20); send(1'b0, 32'd300); drain();
    send(1'b1, 32'd350); send(1'b0, 32'd400); drain();

    cur_req = "R4";
    do_reset(1'b0, 32'd0, 32'd10);
    send(1'b1, 32'd100); send(1'b0, 32'd110); drain();
    send(1'b1, 32'd200); send(1'b0, 32'd205); drain();
    send(1'b1, 32'd0);   send(1'b0, 32'd5);   drain();
    send(1'b1, 32'd300); send(1'b0, 32'd311); drain();

    cur_req = "R6";
    do_reset(1'b0, 32'd0, 32'd0);
    send(1'b0, 32'd5); drain();
    check(proto_err == 1'b1, "R6", "flag after stray fall", longint'(proto_err), 1);
    send(1'b1, 32'd10); send(1'b0, 32'd30); drain();
    check(proto_err == 1'b1, "R6", "flag stays set", longint'(proto_err), 1);

    cur_req = "R1";
    do_reset(1'b1, 32'd2, 32'd1);
    @(negedge clk);
    check(proto_err == 1'b0, "R1", "flag cleared by reset", longint'(proto_err), 0);
    cur_req = "R5";
    send(1'b0, 32'd10); drain();
    check(proto_err == 1'b0, "R5", "no error on leading fall", longint'(proto_err), 0);
    send(1'b1, 32'd20); send(1'b0, 32'd40); drain();

    cur_req = "R7";
    do_reset(1'b0, 32'd5, 32'd5);
    send(1'b1, 32'd10); send(1'b1, 32'd20); send(1'b0, 32'd50); drain();
    check(proto_err == 1'b1, "R7", "flag after double rise", longint'(proto_err), 1);

    cur_req = "R8";
    do_reset(1'b0, 32'd3, 32'd2);
    bp_on = 1'b1;
    seed = 32'd12345;
    t = 10;
    for (int k = 0; k < 60; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      t = t + 1 + (seed >> 16) % 20;
      send(1'b1, t[TS_W-1:0]);
      seed = seed * 32'd1103515245 + 32'd12345;
      t = t + 1 + (seed >> 16) % 20;
      send(1'b0, t[TS_W-1:0]);
    end
    drain();
    bp_on = 1'b0;
    repeat (3) @(posedge clk);
    summary();
    $finish;
  end

endmodule